// File: doc/BRIEF.md
# Tri-State Phase-Frequency Detector

This block compares two streams of single-cycle edge strobes, one taken from the divided oscillator (`fv_stb`) and one from the reference divider (`fr_stb`). From them it produces a loop-error signal for a frequency synthesizer. Two internal flags record which edge has arrived first. While exactly one flag is set, a single-ended error output is enabled. It drives low when the oscillator edge came first, meaning the oscillator leads or runs fast, and high when the reference edge came first, meaning the oscillator lags or runs slow. When the edges coincide the output stays disabled, which is the high-impedance state.

The output is modelled as a data bit plus an output enable, so that the pad can be placed elsewhere. The two flags are also brought out as a pair of double-ended pulse outputs for a differential charge pump. A lock indicator rises after a programmable number of consecutive comparisons whose edges arrived within a programmable tolerance of each other. It falls on the first comparison that misses that tolerance.

Top module: `pfd_tristate`

## Requirements
- R1: After a clock edge that samples `fv_stb` high, `phi_v` is high. It remains high until a clock edge at which both flags were set.
- R2: After a clock edge that samples `fr_stb` high, `phi_r` is high. It remains high until a clock edge at which both flags were set.
- R3: Further strobes on the side whose flag is already set do not change the outputs. The flag stays set and the error output keeps its polarity until the other edge arrives.
- R4: In a cycle where `phi_v` and `phi_r` are both high, the next clock edge clears both flags. A strobe sampled at that same edge sets its own flag again.
- R5: `err_oe` is high exactly when one of `phi_v`/`phi_r` is high. `err_drive` is 0 when `phi_v` is the set flag and 1 when `phi_r` is the set flag.
- R6: Strobes sampled at the same edge while both flags are clear never raise `err_oe`. Both pulse outputs are high for one cycle and then clear.
- R7: A comparison completes in each cycle where both flags are set. It counts as good when the number of preceding cycles with exactly one flag set is at most `LOCK_TOL`. `locked` rises on the clock edge that evaluates the `LOCK_COUNT`-th consecutive good comparison.
- R8: A comparison that is not good clears `locked` on the edge that evaluates it, and the count of good comparisons starts again from zero.
- R9: While `rst` is high and after it is released, with no strobes, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fv_stb | input | 1 | One-cycle strobe marking a divided-oscillator edge |
| fr_stb | input | 1 | One-cycle strobe marking a reference edge |
| err_drive | output | 1 | Value driven on the single-ended error output |
| err_oe | output | 1 | Enable for the single-ended error output (0 = high impedance) |
| phi_v | output | 1 | Double-ended pulse, high while the oscillator flag is set |
| phi_r | output | 1 | Double-ended pulse, high while the reference flag is set |
| locked | output | 1 | Lock indication |

## Verification
The bench sweeps the relative placement of the two edges over a window of plus and minus three cycles. In every cycle it checks the enable, the polarity and both pulses. A design with swapped polarity would drive high while the oscillator leads. One that forgets the coincident case would emit a one-cycle enable for simultaneous edges. The bench also places a fresh edge in the cycle in which both flags are being cleared; a design that drops that edge loses a whole comparison. It repeats oscillator edges before the reference arrives; a design that counted them would change state early. The lock sequence walks across the tolerance boundary. An off-by-one in the error-length count would lock on a two-cycle error, or refuse to lock on a one-cycle error.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // Phase flags held by the detector core
    typedef struct packed {
        logic v;   // oscillator edge seen, waiting for reference
        logic r;   // reference edge seen, waiting for oscillator
    } pfd_flags_t;

    // Single-ended error output state
    typedef enum logic [1:0] {
        ERR_HIZ  = 2'b00,
        ERR_LOW  = 2'b10,
        ERR_HIGH = 2'b11
    } err_state_e;

    function automatic err_state_e flags_to_err(input pfd_flags_t f);
        if (f.v && !f.r)      return ERR_LOW;
        else if (f.r && !f.v) return ERR_HIGH;
        else                  return ERR_HIZ;
    endfunction

    function automatic logic both_set(input pfd_flags_t f);
        return f.v & f.r;
    endfunction

    function automatic logic one_set(input pfd_flags_t f);
        return f.v ^ f.r;
    endfunction

endpackage

// File: rtl/pfd_flag_core.sv
module pfd_flag_core
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fv_stb,
    input  logic       fr_stb,
    output pfd_flags_t flags
);
    pfd_flags_t flags_q, flags_d;

    always_comb begin
        flags_d = flags_q;
        if (both_set(flags_q)) begin
            flags_d = '0;
        end
        if (fv_stb) flags_d.v = 1'b1;
        if (fr_stb) flags_d.r = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/pfd_err_out.sv
module pfd_err_out
    import pfd_pkg::*;
(
    input  pfd_flags_t flags,
    output logic       err_drive,
    output logic       err_oe,
    output logic       phi_v,
    output logic       phi_r
);
    err_state_e st;

    always_comb begin
        st        = flags_to_err(flags);
        err_oe    = st[1];
        err_drive = st[0];
        phi_v     = flags.v;
        phi_r     = flags.r;
    end
endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det
    import pfd_pkg::*;
#(
    parameter int LOCK_COUNT = 16,
    parameter int LOCK_TOL   = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  pfd_flags_t flags,
    output logic       locked
);
    localparam int RUN_W = $clog2(LOCK_TOL + 2);
    localparam int CNT_W = $clog2(LOCK_COUNT + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(LOCK_TOL + 1);
    localparam logic [RUN_W-1:0] RUN_OK  = RUN_W'(LOCK_TOL);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOCK_COUNT);

    logic [RUN_W-1:0] err_len_q;
    logic [CNT_W-1:0] good_cnt_q;
    logic             lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_len_q  <= '0;
            good_cnt_q <= '0;
            lock_q     <= 1'b0;
        end else if (both_set(flags)) begin
            err_len_q <= '0;
            if (err_len_q <= RUN_OK) begin
                if (good_cnt_q != CNT_MAX) good_cnt_q <= good_cnt_q + 1'b1;
                lock_q <= (good_cnt_q + 1'b1 >= CNT_MAX) || (good_cnt_q == CNT_MAX);
            end else begin
                good_cnt_q <= '0;
                lock_q     <= 1'b0;
            end
        end else if (one_set(flags)) begin
            if (err_len_q != RUN_MAX) err_len_q <= err_len_q + 1'b1;
        end else begin
            err_len_q <= '0;
        end
    end

    assign locked = lock_q;
endmodule

// File: rtl/pfd_tristate.sv
module pfd_tristate
    import pfd_pkg::*;
#(
    parameter int LOCK_COUNT = 16,
    parameter int LOCK_TOL   = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic fv_stb,
    input  logic fr_stb,
    output logic err_drive,
    output logic err_oe,
    output logic phi_v,
    output logic phi_r,
    output logic locked
);
    pfd_flags_t flags;

    pfd_flag_core u_core (
        .clk    (clk),
        .rst    (rst),
        .fv_stb (fv_stb),
        .fr_stb (fr_stb),
        .flags  (flags)
    );

    pfd_err_out u_out (
        .flags     (flags),
        .err_drive (err_drive),
        .err_oe    (err_oe),
        .phi_v     (phi_v),
        .phi_r     (phi_r)
    );

    pfd_lock_det #(
        .LOCK_COUNT (LOCK_COUNT),
        .LOCK_TOL   (LOCK_TOL)
    ) u_lock (
        .clk    (clk),
        .rst    (rst),
        .flags  (flags),
        .locked (locked)
    );
endmodule

// File: rtl/pfd_tristate_checker.sv
module pfd_tristate_checker #(
    parameter int LOCK_TOL = 1
) (
    input logic clk,
    input logic rst,
    input logic fv_stb,
    input logic fr_stb,
    input logic err_drive,
    input logic err_oe,
    input logic phi_v,
    input logic phi_r,
    input logic locked
);
    logic [7:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)                 run_q <= '0;
        else if (phi_v && phi_r) run_q <= '0;
        else if (err_oe && run_q != 8'hFF) run_q <= run_q + 8'd1;
        else if (!err_oe)        run_q <= '0;
    end

    p_set_v_r1: assert property (@(posedge clk) disable iff (rst)
        fv_stb |=> phi_v);

    p_set_r_r2: assert property (@(posedge clk) disable iff (rst)
        fr_stb |=> phi_r);

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (err_oe && !fr_stb && !fv_stb) |=> (err_oe && $stable(err_drive)));

    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (phi_v && phi_r) |=> (phi_v == $past(fv_stb) && phi_r == $past(fr_stb)));

    p_pol_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(err_oe) && !err_drive) |-> $past(fv_stb));

    p_coinc_r6: assert property (@(posedge clk) disable iff (rst)
        (!phi_v && !phi_r && fv_stb && fr_stb) |=> !err_oe);

    p_unlock_r8: assert property (@(posedge clk) disable iff (rst)
        (phi_v && phi_r && run_q > 8'(LOCK_TOL)) |=> !locked);

    p_reset_r9: assert property (@(posedge clk)
        $past(rst) |-> (!err_oe && !phi_v && !phi_r && !locked));
endmodule

bind pfd_tristate pfd_tristate_checker #(.LOCK_TOL(LOCK_TOL)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fv_stb    (fv_stb),
    .fr_stb    (fr_stb),
    .err_drive (err_drive),
    .err_oe    (err_oe),
    .phi_v     (phi_v),
    .phi_r     (phi_r),
    .locked    (locked)
);

// File: tb/pfd_tristate_bench.sv
module pfd_tristate_bench;
    localparam int LCOUNT = 4;
    localparam int LTOL   = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fv_stb = 1'b0;
    logic fr_stb = 1'b0;
    logic err_drive, err_oe, phi_v, phi_r, locked;

    int checks = 0;
    int errors = 0;
    int good_run = 0;

    always #4 clk = ~clk;

    pfd_tristate #(.LOCK_COUNT(LCOUNT), .LOCK_TOL(LTOL)) u_pfd_tristate (
        .clk (clk), .rst (rst), .fv_stb (fv_stb), .fr_stb (fr_stb),
        .err_drive (err_drive), .err_oe (err_oe),
        .phi_v (phi_v), .phi_r (phi_r), .locked (locked)
    );

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {oe,drv,pv,pr,lk} actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input logic a, input logic b);
        fv_stb = a;
        fr_stb = b;
        @(posedge clk);
        #2;
        fv_stb = 1'b0;
        fr_stb = 1'b0;
    endtask

    function automatic logic [4:0] got();
        return {err_oe, err_drive, phi_v, phi_r, locked};
    endfunction

    // place edges with offset d (d>0: oscillator first) and check each cycle
    task automatic pair(input int d);
        int ad;
        logic lk_exp;
        ad = (d < 0) ? -d : d;
        lk_exp = locked;
        for (int s = 0; s <= ad + 2; s++) begin
            logic [3:0] e;
            tick((d >= 0) ? (s == 0) : (s == ad), (d >= 0) ? (s == d) : (s == 0));
            if (s < ad)       e = (d > 0) ? 4'b1010 : 4'b1101; // R5
            else if (s == ad) e = 4'b0011;                      // R4/R6 comparison
            else              e = 4'b0000;
            if (s == ad + 1) begin
                good_run = (ad <= LTOL) ? good_run + 1 : 0;
                lk_exp = (good_run >= LCOUNT);
            end
            if (s >= ad + 1) chk((ad <= LTOL) ? "R7" : "R8", got(), {e, lk_exp});
            else chk(d == 0 ? "R6" : "R5", got()[4:1], e[3:0]);
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R9", got(), 5'b00000);
        rst = 1'b0;
        tick(1'b0, 1'b0);
        chk("R9", got(), 5'b00000);

        // R7: lock builds over good comparisons, R8: drops on a bad one
        pair(0); pair(1); pair(-1);
        chk("R7", {4'b0, locked}, 5'b00000);
        pair(0);
        chk("R7", {4'b0, locked}, 5'b00001);
        pair(1);
        pair(2);
        chk("R8", {4'b0, locked}, 5'b00000);

        // R1, R4: fresh oscillator edge in the clearing cycle is kept
        tick(1'b1, 1'b0);
        chk("R1", got()[4:1], 4'b1010);
        tick(1'b0, 1'b1);
        chk("R4", got()[4:1], 4'b0011);
        tick(1'b1, 1'b0);
        chk("R4", got()[4:1], 4'b1010);
        tick(1'b0, 1'b1);
        chk("R2", got()[4:1], 4'b0011);
        tick(1'b0, 1'b0);
        chk("R4", got()[4:1], 4'b0000);
        good_run += 2;

        // R3: repeated oscillator edges before the reference
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b1, 1'b0);
        chk("R3", got()[4:1], 4'b1010);
        tick(1'b1, 1'b0);
        chk("R3", got()[4:1], 4'b1010);
        tick(1'b0, 1'b1);
        chk("R3", got()[4:1], 4'b0011);
        tick(1'b0, 1'b0);
        good_run = 0;
        chk("R8", got(), 5'b00000);

        // R3 mirror: repeated reference edges
        tick(1'b0, 1'b1);
        tick(1'b0, 1'b1);
        chk("R3", got()[4:1], 4'b1101);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        good_run = 0;
        chk("R8", got(), 5'b00000);

        // full offset sweep, repeated to cross lock thresholds
        for (int rep = 0; rep < 3; rep++)
            for (int d = -3; d <= 3; d++) pair(d);
        for (int k = 0; k < LCOUNT + 1; k++) pair((k % 2 == 0) ? 1 : -1);
        chk("R7", {4'b0, locked}, 5'b00001);
        pair(-3);
        chk("R8", {4'b0, locked}, 5'b00000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule